// File: doc/BRIEF.md
# Speculative Load Address Check Table

This block guards loads that were scheduled ahead of stores whose addresses could not be shown to differ. When such a load executes, the block stores the doubleword address it read, keyed by the number of the register the load writes. Every later store is compared against all live entries at once, and any entry whose doubleword the store touches is dropped. At the point where the load originally stood, a check operation names the same register. The block answers whether the entry is still live. A failed answer tells the pipeline to repeat the load at that point.

The table is fully associative and holds a fixed number of entries. When it is full, a new load takes the slot of the entry recorded longest ago. A load to a register that already has an entry reuses that entry. A check that finds a live entry passes and releases the entry. Every check gets its answer exactly one cycle after it is issued.

Top module: `spec_ld_guard`

## Requirements
- R1: A synchronous reset (active high `rst`) drops every entry and holds `rspValid` low. A check issued after reset, with no load recorded since, fails.
- R2: `rspValid` is high in the cycle after a cycle with `chkValid` high, and low otherwise. `rspPass` is only ever high together with `rspValid`.
- R3: After a load records register r, a check of r with no conflicting store in between passes.
- R4: Addresses are compared on 8-byte doublewords, meaning address bits above bit 2. A store whose doubleword equals a recorded one invalidates that entry, whatever its low three bits are. A store to any other doubleword leaves the entry live.
- R5: A check that passes releases its entry, so a second check of the same register fails.
- R6: A check of a register that was never recorded fails.
- R7: A new load to a register that already has a live entry replaces that entry's address. A later store to the old address then leaves the check passing, and no further slot is used.
- R8: With all 8 entries live, a load to a new register evicts the entry recorded longest ago. A check of the evicted register fails, and the other entries stay intact.
- R9: When a load and a store to the same doubleword arrive in the same cycle, the load is recorded and is not invalidated by that store.
- R10: A store in the same cycle as a check, matching the checked entry's doubleword, makes that check fail.
- R11: A check and a load to the same register in the same cycle: the check is answered from the entry as it stood before that cycle, and the new load stays recorded afterwards.
- R12: Re-recording a register makes it the most recently recorded entry for eviction purposes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ldValid | input | 1 | Speculative load executed this cycle |
| ldReg | input | REG_W | Destination register of the speculative load |
| ldAddr | input | ADDR_W | Byte address the speculative load accessed |
| stValid | input | 1 | Store executed this cycle |
| stAddr | input | ADDR_W | Byte address of the store |
| chkValid | input | 1 | Check operation issued this cycle |
| chkReg | input | REG_W | Register whose speculation is checked |
| rspValid | output | 1 | Check answer valid (one cycle after the check) |
| rspPass | output | 1 | Speculation still valid; low means reload required |

## Verification
Directed sequences separate the cases that a simple hit-or-miss table would merge. They cover stores that touch another byte of the same doubleword versus the neighbouring doubleword, overwriting a register versus adding a second slot, and eviction order after a register is re-recorded. Same-cycle collisions are also tried: a load with a store, a check with a store, and a check with a load. These show which of the two operations takes precedence. A long random phase then draws registers and addresses from small pools, so that overwrites, store conflicts, evictions and repeated checks happen often and overlap. Each answer is compared with a reference table kept in the bench.

// File: rtl/slg_pkg.sv
package slg_pkg;

  // Strobes passed from control to datapath each cycle.
  typedef struct packed {
    logic ldWrite;    // capture load address/tag into the selected slot
    logic stSnoop;    // compare store address against every slot
    logic chkLookup;  // compare check tag against every slot
  } slgStrobe_t;

endpackage

// File: rtl/spec_ld_guard_dp.sv
module spec_ld_guard_dp
  import slg_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int REG_W   = 5,
  parameter int ADDR_W  = 32,
  parameter int DW_LSB  = 3,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int LINE_W = ADDR_W - DW_LSB
) (
  input  logic               clk,
  input  slgStrobe_t         strobe,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [REG_W-1:0]   ldReg,
  input  logic [ADDR_W-1:0]  ldAddr,
  input  logic [ADDR_W-1:0]  stAddr,
  input  logic [REG_W-1:0]   chkReg,
  output logic [ENTRIES-1:0] ldTagVec,
  output logic [ENTRIES-1:0] chkTagVec,
  output logic [ENTRIES-1:0] stHitVec
);

  logic [LINE_W-1:0] ldLine;
  logic [LINE_W-1:0] stLine;

  assign ldLine = ldAddr[ADDR_W-1:DW_LSB];
  assign stLine = stAddr[ADDR_W-1:DW_LSB];

  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_slot
    logic [REG_W-1:0]  tagQ;
    logic [LINE_W-1:0] lineQ;

    always_ff @(posedge clk) begin
      if (strobe.ldWrite && (wrIdx == IDX_W'(gi))) begin
        tagQ  <= ldReg;
        lineQ <= ldLine;
      end
    end

    assign ldTagVec[gi]  = strobe.ldWrite   && (tagQ == ldReg);
    assign chkTagVec[gi] = strobe.chkLookup && (tagQ == chkReg);
    assign stHitVec[gi]  = strobe.stSnoop   && (lineQ == stLine);
  end

endmodule

// File: rtl/spec_ld_guard_ctrl.sv
module spec_ld_guard_ctrl
  import slg_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ldValid,
  input  logic               stValid,
  input  logic               chkValid,
  input  logic [ENTRIES-1:0] ldTagVec,
  input  logic [ENTRIES-1:0] chkTagVec,
  input  logic [ENTRIES-1:0] stHitVec,
  output slgStrobe_t         strobe,
  output logic [IDX_W-1:0]   wrIdx,
  output logic [ENTRIES-1:0] entryValid,
  output logic               rspValid,
  output logic               rspPass
);

  logic [ENTRIES-1:0] validQ;
  // olderQ[i][j] set: slot i was recorded before slot j
  logic [ENTRIES-1:0] olderQ [ENTRIES];

  logic [ENTRIES-1:0] sameTagVec;
  logic [ENTRIES-1:0] freeVec;
  logic [ENTRIES-1:0] oldestVec;
  logic [ENTRIES-1:0] chkHitVec;
  logic [ENTRIES-1:0] killVec;
  logic [ENTRIES-1:0] validD;
  logic               chkPassNow;

  function automatic logic [IDX_W-1:0] firstSet(input logic [ENTRIES-1:0] vec);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int k = ENTRIES - 1; k >= 0; k--) begin
      if (vec[k]) idx = IDX_W'(k);
    end
    return idx;
  endfunction

  assign strobe.ldWrite   = ldValid;
  assign strobe.stSnoop   = stValid;
  assign strobe.chkLookup = chkValid;

  assign sameTagVec = ldTagVec & validQ;
  assign freeVec    = ~validQ;
  assign chkHitVec  = chkTagVec & validQ;
  assign chkPassNow = |(chkHitVec & ~stHitVec);

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      oldestVec[i] = validQ[i];
      for (int j = 0; j < ENTRIES; j++) begin
        if ((j != i) && validQ[j] && !olderQ[i][j]) oldestVec[i] = 1'b0;
      end
    end
  end

  always_comb begin
    if (|sameTagVec)   wrIdx = firstSet(sameTagVec);
    else if (|freeVec) wrIdx = firstSet(freeVec);
    else               wrIdx = firstSet(oldestVec);
  end

  always_comb begin
    killVec = stHitVec | (chkValid ? chkHitVec : '0);
    for (int i = 0; i < ENTRIES; i++) begin
      if (ldValid && (wrIdx == IDX_W'(i))) validD[i] = 1'b1;
      else                                 validD[i] = validQ[i] & ~killVec[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      validQ   <= '0;
      rspValid <= 1'b0;
      rspPass  <= 1'b0;
      for (int i = 0; i < ENTRIES; i++) olderQ[i] <= '0;
    end else begin
      validQ   <= validD;
      rspValid <= chkValid;
      rspPass  <= chkValid & chkPassNow;
      if (ldValid) begin
        for (int j = 0; j < ENTRIES; j++) begin
          if (wrIdx != IDX_W'(j)) begin
            olderQ[j][wrIdx] <= 1'b1;
            olderQ[wrIdx][j] <= 1'b0;
          end
        end
      end
    end
  end

  assign entryValid = validQ;

endmodule

// File: rtl/spec_ld_guard.sv
module spec_ld_guard
  import slg_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int REG_W   = 5,
  parameter int ADDR_W  = 32,
  parameter int DW_LSB  = 3,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ldValid,
  input  logic [REG_W-1:0]  ldReg,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic              stValid,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic              chkValid,
  input  logic [REG_W-1:0]  chkReg,
  output logic              rspValid,
  output logic              rspPass
);

  slgStrobe_t         strobe;
  logic [IDX_W-1:0]   wrIdx;
  logic [ENTRIES-1:0] ldTagVec;
  logic [ENTRIES-1:0] chkTagVec;
  logic [ENTRIES-1:0] stHitVec;
  logic [ENTRIES-1:0] entryValid;

  spec_ld_guard_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .ldValid    (ldValid),
    .stValid    (stValid),
    .chkValid   (chkValid),
    .ldTagVec   (ldTagVec),
    .chkTagVec  (chkTagVec),
    .stHitVec   (stHitVec),
    .strobe     (strobe),
    .wrIdx      (wrIdx),
    .entryValid (entryValid),
    .rspValid   (rspValid),
    .rspPass    (rspPass)
  );

  spec_ld_guard_dp #(
    .ENTRIES (ENTRIES),
    .REG_W   (REG_W),
    .ADDR_W  (ADDR_W),
    .DW_LSB  (DW_LSB)
  ) u_dp (
    .clk       (clk),
    .strobe    (strobe),
    .wrIdx     (wrIdx),
    .ldReg     (ldReg),
    .ldAddr    (ldAddr),
    .stAddr    (stAddr),
    .chkReg    (chkReg),
    .ldTagVec  (ldTagVec),
    .chkTagVec (chkTagVec),
    .stHitVec  (stHitVec)
  );

endmodule

// File: rtl/spec_ld_guard_chk.sv
module spec_ld_guard_chk #(
  parameter int ENTRIES = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               ldValid,
  input logic               chkValid,
  input logic               rspValid,
  input logic               rspPass,
  input logic [ENTRIES-1:0] entryValid
);

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!rspValid && (entryValid == '0)));

  // R2
  rsp_follows_chk_chk: assert property (@(posedge clk) disable iff (rst)
    chkValid |=> rspValid);

  // R2
  rsp_only_after_chk_chk: assert property (@(posedge clk) disable iff (rst)
    !chkValid |=> !rspValid);

  // R2
  pass_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rspPass |-> rspValid);

  // R3
  load_recorded_chk: assert property (@(posedge clk) disable iff (rst)
    ldValid |=> (entryValid != '0));

  // R7
  one_slot_per_load_chk: assert property (@(posedge clk) disable iff (rst)
    ldValid |=> ($countones(entryValid) <= $countones($past(entryValid)) + 1));

  // R8
  no_growth_without_load_chk: assert property (@(posedge clk) disable iff (rst)
    !ldValid |=> ($countones(entryValid) <= $countones($past(entryValid))));

endmodule

bind spec_ld_guard spec_ld_guard_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ldValid    (ldValid),
  .chkValid   (chkValid),
  .rspValid   (rspValid),
  .rspPass    (rspPass),
  .entryValid (entryValid)
);

// File: tb/spec_ld_guard_bench.sv
`timescale 1ns/1ps
module spec_ld_guard_bench;

  localparam int NE = 8;

  logic        clk = 1'b0;
  logic        rst;
  logic        ldValid;
  logic [4:0]  ldReg;
  logic [31:0] ldAddr;
  logic        stValid;
  logic [31:0] stAddr;
  logic        chkValid;
  logic [4:0]  chkReg;
  logic        rspValid;
  logic        rspPass;

  int vectors = 0;
  int fails   = 0;

  // reference table
  bit mV [NE];
  int mR [NE];
  int mL [NE];
  int mS [NE];
  int stampCtr = 0;

  always #10 clk = ~clk;

  spec_ld_guard u_spec_ld_guard (
    .clk(clk), .rst(rst),
    .ldValid(ldValid), .ldReg(ldReg), .ldAddr(ldAddr),
    .stValid(stValid), .stAddr(stAddr),
    .chkValid(chkValid), .chkReg(chkReg),
    .rspValid(rspValid), .rspPass(rspPass)
  );

  task automatic modelReset();
    for (int i = 0; i < NE; i++) begin
      mV[i] = 0; mR[i] = 0; mL[i] = 0; mS[i] = 0;
    end
  endtask

  task automatic modelStep(input bit ld, input int lr, input int la,
                           input bit st, input int sa,
                           input bit ck, input int cr, output bit pass);
    int tgt;
    bit hit [NE];
    pass = 0;
    for (int i = 0; i < NE; i++)
      hit[i] = mV[i] && ck && (mR[i] == cr);
    for (int i = 0; i < NE; i++)
      if (hit[i] && !(st && ((sa >>> 3) == mL[i]))) pass = 1;
    tgt = -1;
    if (ld) begin
      for (int i = 0; i < NE; i++) if (tgt < 0 && mV[i] && mR[i] == lr) tgt = i;
      for (int i = 0; i < NE; i++) if (tgt < 0 && !mV[i]) tgt = i;
      if (tgt < 0) begin
        tgt = 0;
        for (int i = 1; i < NE; i++) if (mS[i] < mS[tgt]) tgt = i;
      end
    end
    for (int i = 0; i < NE; i++) begin
      if (i == tgt) begin
        mV[i] = 1; mR[i] = lr; mL[i] = la >>> 3; stampCtr++; mS[i] = stampCtr;
      end else if (mV[i] && ((st && ((sa >>> 3) == mL[i])) || hit[i])) begin
        mV[i] = 0;
      end
    end
  endtask

  // expP: -1 uses the reference table, 0/1 forces the expected answer
  task automatic doCycle(input bit ld, input int lr, input int la,
                         input bit st, input int sa,
                         input bit ck, input int cr,
                         input int expP, input string tag);
    bit mp;
    bit exp;
    ldValid = ld; ldReg = 5'(lr); ldAddr = 32'(la);
    stValid = st; stAddr = 32'(sa);
    chkValid = ck; chkReg = 5'(cr);
    modelStep(ld, lr, la, st, sa, ck, cr, mp);
    exp = (expP < 0) ? mp : expP[0];
    @(negedge clk);
    vectors++;
    if (rspValid !== ck) begin
      fails++;
      $display("FAIL R2 rspValid actual=%b expected=%b", rspValid, ck);
    end
    if (ck) begin
      vectors++;
      if (rspPass !== exp) begin
        fails++;
        $display("FAIL %s rspPass reg=%0d actual=%b expected=%b", tag, cr, rspPass, exp);
      end
    end
  endtask

  task automatic idle();
    doCycle(0, 0, 0, 0, 0, 0, 0, -1, "R2");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240917));
    modelReset();
    rst = 1; ldValid = 0; ldReg = 0; ldAddr = 0; stValid = 0; stAddr = 0;
    chkValid = 0; chkReg = 0;
    repeat (3) @(negedge clk);
    vectors++;
    if (rspValid !== 1'b0) begin
      fails++;
      $display("FAIL R1 rspValid in reset actual=%b expected=0", rspValid);
    end
    rst = 0;

    // R1 / R6: empty table after reset
    doCycle(0, 0, 0, 0, 0, 1, 3, 0, "R1");
    doCycle(0, 0, 0, 0, 0, 1, 0, 0, "R6");
    // R3, R5
    doCycle(1, 1, 'h100, 0, 0, 0, 0, -1, "R3");
    doCycle(0, 0, 0, 0, 0, 1, 1, 1, "R3");
    doCycle(0, 0, 0, 0, 0, 1, 1, 0, "R5");
    // R4: same doubleword other byte kills, neighbour doubleword does not
    doCycle(1, 2, 'h200, 0, 0, 0, 0, -1, "R4");
    doCycle(0, 0, 0, 1, 'h205, 0, 0, -1, "R4");
    doCycle(0, 0, 0, 0, 0, 1, 2, 0, "R4");
    doCycle(1, 2, 'h200, 0, 0, 0, 0, -1, "R4");
    doCycle(0, 0, 0, 1, 'h208, 0, 0, -1, "R4");
    doCycle(0, 0, 0, 1, 'h1F8, 0, 0, -1, "R4");
    doCycle(0, 0, 0, 0, 0, 1, 2, 1, "R4");
    // R7: overwrite same register
    doCycle(1, 4, 'h300, 0, 0, 0, 0, -1, "R7");
    doCycle(1, 4, 'h400, 0, 0, 0, 0, -1, "R7");
    doCycle(0, 0, 0, 1, 'h300, 0, 0, -1, "R7");
    doCycle(0, 0, 0, 0, 0, 1, 4, 1, "R7");
    doCycle(1, 4, 'h400, 0, 0, 0, 0, -1, "R7");
    doCycle(0, 0, 0, 1, 'h404, 0, 0, -1, "R7");
    doCycle(0, 0, 0, 0, 0, 1, 4, 0, "R7");
    // R9: load and store same doubleword same cycle
    doCycle(1, 5, 'h500, 1, 'h503, 0, 0, -1, "R9");
    doCycle(0, 0, 0, 0, 0, 1, 5, 1, "R9");
    // R10: store in the same cycle as the check
    doCycle(1, 6, 'h600, 0, 0, 0, 0, -1, "R10");
    doCycle(0, 0, 0, 1, 'h600, 1, 6, 0, "R10");
    doCycle(0, 0, 0, 0, 0, 1, 6, 0, "R10");
    // R11: check and load to same register same cycle
    doCycle(1, 7, 'h700, 0, 0, 0, 0, -1, "R11");
    doCycle(1, 7, 'h710, 0, 0, 1, 7, 1, "R11");
    doCycle(0, 0, 0, 1, 'h700, 0, 0, -1, "R11");
    doCycle(0, 0, 0, 0, 0, 1, 7, 1, "R11");
    doCycle(0, 0, 0, 0, 0, 1, 7, 0, "R11");
    // R8 / R12: fill, re-record oldest, then overflow
    for (int r = 8; r < 16; r++) doCycle(1, r, 'h1000 + 8 * r, 0, 0, 0, 0, -1, "R8");
    doCycle(1, 8, 'h1040, 0, 0, 0, 0, -1, "R12");
    doCycle(1, 16, 'h2080, 0, 0, 0, 0, -1, "R8");
    doCycle(0, 0, 0, 0, 0, 1, 9, 0, "R8");
    doCycle(0, 0, 0, 0, 0, 1, 8, 1, "R12");
    for (int r = 10; r < 17; r++) doCycle(0, 0, 0, 0, 0, 1, r, 1, "R8");
    idle();

    // random mix against the reference table
    for (int n = 0; n < 3000; n++) begin
      bit ld, st, ck;
      int lr, la, sa, cr;
      ld = ($urandom_range(0, 9) < 4);
      st = ($urandom_range(0, 9) < 4);
      ck = ($urandom_range(0, 9) < 4);
      lr = $urandom_range(0, 11);
      cr = $urandom_range(0, 11);
      la = 'h3000 + 8 * $urandom_range(0, 5) + $urandom_range(0, 7);
      sa = 'h3000 + 8 * $urandom_range(0, 7) + $urandom_range(0, 7);
      doCycle(ld, lr, la, st, sa, ck, cr, -1, "R3");
    end
    idle();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule